// File: doc/BRIEF.md
# Chip-Select External Bus Cycle Controller

This block turns 32-bit requests from an on-chip master into cycles on a 16-bit external bus. It serves a small set of chip selects, and each one has its own control word. The control word sets four things: how a cycle ends, how many wait clocks a beat takes, whether wide reads are sent as a burst, and whether wide writes are sent as a burst. Address decoding is not done here. The requester names the chip select directly with each request.

The requester places a request for one clock while the block is idle. The request carries the chip select, a byte address, the direction, the size (16-bit word or 32-bit longword) and the write data. The block drives the strobe for the selected chip select, a word address without its lowest bit, the direction and the write lane. Each beat ends in one of two ways, chosen by the control word:

- an internal acknowledge after a counted number of wait clocks, or
- only when the external acknowledge input is high.

A longword is moved as two word beats, most significant half first. The two beats are either separated by a clock with no strobe active, or run back to back as a burst. When the last beat has ended, the block raises a one-clock done pulse, and the assembled read data is held on its output.

Top module: `csbus_ctrl`

## Requirements
- R1: Each control word is 16 bits: wait count in bits 13:10, internal-acknowledge enable in bit 8, port-size code in bits 7:6, burst-read enable in bit 4, burst-write enable in bit 3. Every other bit reads 0 and ignores writes. After reset every control word reads 0x3D80 (wait 15, internal acknowledge on, code 10, no bursts).
- R2: With internal acknowledge enabled, every beat lasts wait+1 clocks. `bus_ta` is high in the last of those clocks, and `ext_ack` has no effect on when the beat ends.
- R3: With internal acknowledge disabled, a beat ends only in the clock in which `ext_ack` is high, whatever the wait count is.
- R4: All four port-size codes (00, 01, 10, 11) give the same 16-bit lane behaviour. Codes 00 and 01 are treated as 16-bit.
- R5: `bus_addr` carries byte-address bits 31:1 of the request. The first beat uses the request address, and `bus_addr` stays stable within a beat.
- R6: When a longword's direction has its burst enable cleared, the longword takes two separate beats. All strobes are inactive for exactly one clock between the two beats, and `bus_burst` stays low.
- R7: When a longword's direction has its burst enable set, the two beats run back to back. The strobe stays active, `bus_burst` is high, and the wait count or external acknowledge applies to each beat.
- R8: Longword beats are big-endian. Bits 31:16 go to the request address and bits 15:0 go to the request address + 2 (word address + 1).
- R9: A word access writes `req_wdata[15:0]`. A word read returns the lane value in `rd_data[15:0]`, with `rd_data[31:16]` set to zero.
- R10: `done` is high for exactly one clock, in the clock after the final beat's `bus_ta`. `rd_data` then holds its value until the next read captures data.
- R11: A request presented while a transfer is in progress is ignored.
- R12: At most one strobe of `bus_cs_n` (active low, bit i for chip select i) is low, and it is the one selected by the request. `bus_oe` is high only during write beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for a control word |
| cfg_sel | input | SEL_W | Control word index for write and read |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Control word read value (combinational) |
| req_valid | input | 1 | One-clock request pulse, taken only when idle |
| req_cs | input | SEL_W | Chip select of the request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_long | input | 1 | 1 = 32-bit longword, 0 = 16-bit word |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Assembled read data, valid with done |
| done | output | 1 | One-clock completion pulse |
| bus_addr | output | ADDR_W-1 | External word address (byte bits 31:1) |
| bus_cs_n | output | NUM_CS | Active-low chip-select strobes |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_burst | output | 1 | High while a burst is running |
| bus_ta | output | 1 | Beat-terminating clock |
| bus_wdata | output | 16 | Write lane (upper data half) |
| bus_oe | output | 1 | Write lane enable |
| bus_rdata | input | 16 | Read lane (upper data half) |
| ext_ack | input | 1 | External transfer acknowledge |

## Verification
A wrong beat count or an acknowledge taken from the wrong source changes the clock on which `done` rises. The bench predicts that clock exactly from the wait count or the external delay, so a single-clock slip is reported on that same transfer. A bad half ordering, a missed address step or a wrong split/burst choice shows up at the termination clock of the affected beat, in the logged address, lane value, strobe and `bus_burst`. A wrong capture or reset state shows up in `rd_data` or `cfg_rdata` on the first observation after it.

// File: rtl/csbus_pkg.sv
// Package: shared control-word layout and sequencer state for the
// chip-select bus controller. Assumes a 16-bit control word.
package csbus_pkg;

    localparam int CFG_W  = 16;
    localparam int WS_W   = 4;
    localparam int WS_LSB = 10;
    localparam int AA_BIT = 8;
    localparam int PS_LSB = 6;
    localparam int BR_BIT = 4;
    localparam int BW_BIT = 3;

    typedef struct packed {
        logic [WS_W-1:0] ws;
        logic            aa;
        logic [1:0]      ps;
        logic            br;
        logic            bw;
    } cs_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_t;

    localparam cs_cfg_t CFG_RESET = '{ws: 4'hF, aa: 1'b1, ps: 2'b10, br: 1'b0, bw: 1'b0};

    // Place the fields at their bit positions; every other bit is zero.
    function automatic logic [CFG_W-1:0] cfg_pack(cs_cfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[WS_LSB +: WS_W] = c.ws;
        w[AA_BIT]         = c.aa;
        w[PS_LSB +: 2]    = c.ps;
        w[BR_BIT]         = c.br;
        w[BW_BIT]         = c.bw;
        return w;
    endfunction

    // Pick the fields out of a written word, dropping the other bits.
    function automatic cs_cfg_t cfg_unpack(logic [CFG_W-1:0] w);
        cs_cfg_t c;
        c.ws = w[WS_LSB +: WS_W];
        c.aa = w[AA_BIT];
        c.ps = w[PS_LSB +: 2];
        c.br = w[BR_BIT];
        c.bw = w[BW_BIT];
        return c;
    endfunction

    // Every port-size code maps to a 16-bit lane; the two reserved codes fall back to it.
    function automatic logic port_is_narrow(logic [1:0] code);
        logic n;
        case (code)
            2'b10, 2'b11: n = 1'b1;
            default:      n = 1'b1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/csbus_cfg_regs.sv
// Module: one control word per chip select.
// Written by index and read back combinationally. Only the defined
// fields are stored, so the remaining bits read as zero.
// Assumes NUM_CS >= 1 and that cfg_sel stays below NUM_CS.
module csbus_cfg_regs
    import csbus_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [CFG_W-1:0]          cfg_wdata,
    output logic [CFG_W-1:0]          cfg_rdata,
    output cs_cfg_t [NUM_CS-1:0]      cfg_all
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_word
        // Hold the fields of chip select g; load them on a write that names g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_all[g] <= CFG_RESET;
            end else if (cfg_wr && (cfg_sel == SEL_W'(g))) begin
                cfg_all[g] <= cfg_unpack(cfg_wdata);
            end
        end
    end

    // Read-back mux for the word the index points at.
    always_comb begin
        cfg_rdata = cfg_pack(cfg_all[cfg_sel]);
    end

endmodule

// File: rtl/csbus_beat_timer.sv
// Module: beat termination.
// Counts wait clocks in the current beat. A beat ends when the count
// reaches the programmed wait (internal acknowledge enabled) or in the
// clock ext_ack is high (internal acknowledge disabled).
// Assumes active is high for exactly the clocks of a beat.
module csbus_beat_timer
    import csbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic [WS_W-1:0] ws,
    input  logic            aa,
    input  logic            ext_ack,
    output logic            term
);

    localparam logic [WS_W-1:0] CNT_MAX = '1;

    logic [WS_W-1:0] cnt;

    // Combinational termination, chosen by the acknowledge source.
    always_comb begin
        if (!active) begin
            term = 1'b0;
        end else if (aa) begin
            term = (cnt == ws);
        end else begin
            term = ext_ack;
        end
    end

    // Count the clocks spent in a beat; restart at every beat boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active || term) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/csbus_seq.sv
// Module: transfer sequencer.
// Accepts one request while idle. Latches the request's control
// settings, steps through one or two beats (split with a strobe-free
// gap clock, or as a burst) and pulses done after the final beat.
// Assumes term is only high during ST_BEAT.
module csbus_seq
    import csbus_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_cs,
    input  logic              req_write,
    input  logic              req_long,
    input  cs_cfg_t           req_cfg,
    input  logic              term,
    output logic              accept,
    output logic              in_beat,
    output logic              beat_idx,
    output logic              two_beats,
    output logic              wr,
    output logic              burst,
    output logic [WS_W-1:0]   ws,
    output logic              aa,
    output logic [NUM_CS-1:0] cs_n,
    output logic              done
);

    seq_state_t       state;
    logic [SEL_W-1:0] cs_q;
    logic             last_beat;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign in_beat   = (state == ST_BEAT);
    assign last_beat = !two_beats || beat_idx;

    // Main state machine and the request settings held for the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cs_q      <= '0;
            wr        <= 1'b0;
            two_beats <= 1'b0;
            burst     <= 1'b0;
            ws        <= '0;
            aa        <= 1'b0;
            beat_idx  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state     <= ST_BEAT;
                        cs_q      <= req_cs;
                        wr        <= req_write;
                        two_beats <= req_long && port_is_narrow(req_cfg.ps);
                        burst     <= req_long && (req_write ? req_cfg.bw : req_cfg.br);
                        ws        <= req_cfg.ws;
                        aa        <= req_cfg.aa;
                        beat_idx  <= 1'b0;
                    end
                end
                ST_BEAT: begin
                    if (term) begin
                        if (last_beat) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            beat_idx <= 1'b1;
                            state    <= burst ? ST_BEAT : ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    state <= ST_BEAT;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Decode the active-low strobe of the latched chip select during a beat.
    always_comb begin
        cs_n = '1;
        for (int i = 0; i < NUM_CS; i++) begin
            if (in_beat && (cs_q == SEL_W'(i))) begin
                cs_n[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/csbus_lane.sv
// Module: address and data lane.
// Holds the word address and write data of the accepted request,
// steers the half that belongs to each beat (upper half first) and
// assembles read data from the 16-bit lane.
// Assumes DATA_W == 2 * LANE_W.
module csbus_lane #(
    parameter int ADDR_W = 32,
    parameter int LANE_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic              beat_idx,
    input  logic              two_beats,
    input  logic [LANE_W-1:0] lane_in,
    output logic [ADDR_W-2:0] word_addr,
    output logic [LANE_W-1:0] lane_out,
    output logic [DATA_W-1:0] rd_data
);

    localparam int WA_W = ADDR_W - 1;

    logic [WA_W-1:0]   base_q;
    logic [DATA_W-1:0] wdata_q;
    logic              addr_lsb_unused;

    assign addr_lsb_unused = req_addr[0];

    // Latch address and write data on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            base_q  <= req_addr[ADDR_W-1:1];
            wdata_q <= req_wdata;
        end
    end

    // Capture the lane into the half named by the beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture) begin
            if (!two_beats) begin
                rd_data <= {{(DATA_W-LANE_W){1'b0}}, lane_in};
            end else if (!beat_idx) begin
                rd_data[DATA_W-1:LANE_W] <= lane_in;
            end else begin
                rd_data[LANE_W-1:0] <= lane_in;
            end
        end
    end

    // Beat address and write-half selection.
    always_comb begin
        word_addr = base_q + WA_W'(beat_idx);
        if (two_beats && !beat_idx) begin
            lane_out = wdata_q[DATA_W-1:LANE_W];
        end else begin
            lane_out = wdata_q[LANE_W-1:0];
        end
    end

endmodule

// File: rtl/csbus_ctrl.sv
// Module: chip-select bus cycle controller (top).
// Ties together the control words, the sequencer, the beat timer and
// the lane. The request picks its chip select directly; no address
// decoding is done here.
module csbus_ctrl
    import csbus_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 32,
    parameter int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_long,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    output logic              done,
    output logic [ADDR_W-1:1] bus_addr,
    output logic [NUM_CS-1:0] bus_cs_n,
    output logic              bus_rw,
    output logic              bus_burst,
    output logic              bus_ta,
    output logic [15:0]       bus_wdata,
    output logic              bus_oe,
    input  logic [15:0]       bus_rdata,
    input  logic              ext_ack
);

    localparam int LANE_W = 16;
    localparam int DATA_W = 2 * LANE_W;

    cs_cfg_t [NUM_CS-1:0] cfg_all;
    cs_cfg_t              req_cfg;
    logic                 accept;
    logic                 in_beat;
    logic                 beat_idx;
    logic                 two_beats;
    logic                 wr;
    logic                 burst;
    logic [WS_W-1:0]      ws;
    logic                 aa;
    logic                 term;
    logic                 capture;

    csbus_cfg_regs #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_all   (cfg_all)
    );

    // Settings of the chip select named by the incoming request.
    assign req_cfg = cfg_all[req_cs];

    csbus_seq #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_cs    (req_cs),
        .req_write (req_write),
        .req_long  (req_long),
        .req_cfg   (req_cfg),
        .term      (term),
        .accept    (accept),
        .in_beat   (in_beat),
        .beat_idx  (beat_idx),
        .two_beats (two_beats),
        .wr        (wr),
        .burst     (burst),
        .ws        (ws),
        .aa        (aa),
        .cs_n      (bus_cs_n),
        .done      (done)
    );

    csbus_beat_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_beat),
        .ws      (ws),
        .aa      (aa),
        .ext_ack (ext_ack),
        .term    (term)
    );

    // Read beats store the lane on their terminating clock.
    assign capture = term && !wr;

    csbus_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .DATA_W(DATA_W)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .beat_idx  (beat_idx),
        .two_beats (two_beats),
        .lane_in   (bus_rdata),
        .word_addr (bus_addr),
        .lane_out  (bus_wdata),
        .rd_data   (rd_data)
    );

    assign bus_rw    = !wr;
    assign bus_burst = in_beat && burst;
    assign bus_ta    = term;
    assign bus_oe    = in_beat && wr;

endmodule

// File: rtl/csbus_ctrl_chk.sv
// Module: protocol checker for csbus_ctrl, attached with bind.
// Watches only the block's ports.
module csbus_ctrl_chk #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [ADDR_W-1:1] bus_addr,
    input logic [NUM_CS-1:0] bus_cs_n,
    input logic              bus_rw,
    input logic              bus_burst,
    input logic              bus_ta,
    input logic              bus_oe
);

    logic cs_act;
    assign cs_act = !(&bus_cs_n);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n)); // R12

    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!bus_rw && cs_act)); // R12

    AST_TA_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ta |-> cs_act); // R3

    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_AFTER_TA: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_ta) && !cs_act)); // R10

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act) && !$past(bus_ta)) |-> $stable(bus_addr)); // R5

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_ta) && $past(bus_burst) && bus_burst) |-> (bus_addr == $past(bus_addr) + 1'b1)); // R8

    AST_SPLIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_ta) && !$past(bus_burst)) |-> !cs_act); // R6

endmodule

bind csbus_ctrl csbus_ctrl_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .bus_addr  (bus_addr),
    .bus_cs_n  (bus_cs_n),
    .bus_rw    (bus_rw),
    .bus_burst (bus_burst),
    .bus_ta    (bus_ta),
    .bus_oe    (bus_oe)
);

// File: tb/sim_csbus_ctrl.sv
// Bench: a vector table walked by one loop, then directed cases.
// A responder models the memory and drives ext_ack a set number of
// clocks into each beat; a monitor logs every terminating beat.
module sim_csbus_ctrl;

    localparam int NUM_CS = 4;
    localparam int ADDR_W = 32;
    localparam int SEL_W  = 2;

    typedef struct packed {
        logic [1:0]  cs;
        logic [15:0] cfg;
        logic        wr;
        logic        lng;
        logic [3:0]  dly;
        logic [31:0] addr;
        logic [31:0] wdata;
    } vec_t;

    // cfg: wait in 13:10, internal ack 8, port code 7:6, burst read 4, burst write 3
    localparam vec_t VECS [0:7] = '{
        '{2'd0, 16'h0980, 1'b0, 1'b0, 4'd0, 32'h0000_1000, 32'h0},           // R2 word read, wait 2
        '{2'd1, 16'h01D0, 1'b0, 1'b1, 4'd0, 32'h0000_2004, 32'h0},           // R7 burst read, code 11
        '{2'd2, 16'h0510, 1'b1, 1'b1, 4'd0, 32'h0000_3008, 32'hDEAD_BEEF},   // R6 split write, code 00
        '{2'd3, 16'h0D48, 1'b1, 1'b1, 4'd0, 32'h0001_0010, 32'h1234_5678},   // R7 burst write, code 01
        '{2'd0, 16'h3C80, 1'b0, 1'b1, 4'd2, 32'h0000_0040, 32'h0},           // R3 external ack, split read
        '{2'd1, 16'h0088, 1'b1, 1'b1, 4'd1, 32'h0000_0020, 32'hCAFE_F00D},   // R3 external ack, burst write
        '{2'd2, 16'h1580, 1'b1, 1'b0, 4'd0, 32'h0000_4002, 32'hFFFF_ABCD},   // R2 early ext_ack ignored
        '{2'd3, 16'h0090, 1'b0, 1'b1, 4'd0, 32'h0000_5000, 32'h0}            // R3 burst read, ack at once
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [SEL_W-1:0]  cfg_sel = '0;
    logic [15:0]       cfg_wdata = '0;
    logic [15:0]       cfg_rdata;
    logic              req_valid = 1'b0;
    logic [SEL_W-1:0]  req_cs = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic              req_long = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rd_data;
    logic              done;
    logic [ADDR_W-1:1] bus_addr;
    logic [NUM_CS-1:0] bus_cs_n;
    logic              bus_rw;
    logic              bus_burst;
    logic              bus_ta;
    logic [15:0]       bus_wdata;
    logic              bus_oe;
    logic [15:0]       bus_rdata;
    logic              ext_ack = 1'b0;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    csbus_ctrl #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_cs(req_cs), .req_addr(req_addr), .req_write(req_write),
        .req_long(req_long), .req_wdata(req_wdata), .rd_data(rd_data),
        .done(done), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rw(bus_rw),
        .bus_burst(bus_burst), .bus_ta(bus_ta), .bus_wdata(bus_wdata),
        .bus_oe(bus_oe), .bus_rdata(bus_rdata), .ext_ack(ext_ack)
    );

    function automatic logic [15:0] mem_word(logic [ADDR_W-2:0] wa);
        return wa[15:0] ^ 16'h5A3C;
    endfunction

    assign bus_rdata = mem_word(bus_addr);

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Responder and monitor
    int                ext_dly = 0;
    int                rcnt = 0;
    bit                prev_act = 0;
    bit                prev_ta = 0;
    int                nbeats = 0;
    int                ndone = 0;
    logic [ADDR_W-2:0] log_addr [4];
    logic [15:0]       log_data [4];
    logic [3:0]        log_cs [4];
    logic              log_burst [4];

    initial begin
        forever begin
            @(negedge clk);
            if (&bus_cs_n) begin
                rcnt = 0;
                ext_ack = 1'b0;
            end else begin
                if (!prev_act || prev_ta) rcnt = 0;
                else rcnt++;
                ext_ack = (rcnt == ext_dly);
            end
            #1;
            if (bus_ta) begin
                if (nbeats < 4) begin
                    log_addr[nbeats]  = bus_addr;
                    log_data[nbeats]  = bus_wdata;
                    log_cs[nbeats]    = ~bus_cs_n;
                    log_burst[nbeats] = bus_burst;
                end
                nbeats++;
            end
            if (done) ndone++;
            prev_act = !(&bus_cs_n);
            prev_ta  = bus_ta;
        end
    end

    task automatic write_cfg(logic [1:0] sel, logic [15:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Run one transfer and check latency, beats, addresses, strobes and data.
    task automatic run_vec(vec_t v, bit do_cfg);
        int  k;
        int  len;
        int  dur;
        bit  burst;
        logic [ADDR_W-2:0] wa;
        logic [31:0] exp_rd;
        string tag;
        if (do_cfg) write_cfg(v.cs, v.cfg);
        ext_dly = v.dly;
        @(negedge clk);
        nbeats = 0; ndone = 0;
        req_valid = 1'b1; req_cs = v.cs; req_addr = v.addr;
        req_write = v.wr; req_long = v.lng; req_wdata = v.wdata;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        while (!done && k < 300) begin
            @(negedge clk);
            k++;
        end
        len   = (v.cfg[8] ? int'(v.cfg[13:10]) : int'(v.dly)) + 1;
        burst = v.lng && (v.wr ? v.cfg[3] : v.cfg[4]);
        dur   = !v.lng ? len : (burst ? 2 * len : 2 * len + 1);
        tag   = v.cfg[8] ? "R2" : "R3";
        check(tag, "done clock", k, dur + 1);
        check(v.lng ? (burst ? "R7" : "R6") : "R9", "beat count", nbeats, v.lng ? 2 : 1);
        wa = v.addr[31:1];
        check("R5", "first beat address", log_addr[0], wa);
        check("R12", "strobe", {28'h0, log_cs[0]}, 32'h1 << v.cs);
        check("R7", "burst flag", {31'h0, log_burst[0]}, {31'h0, burst});
        if (v.lng) check("R8", "second beat address", log_addr[1], wa + 1'b1);
        if (v.wr) begin
            check(v.lng ? "R8" : "R9", "first beat lane", log_data[0], v.lng ? v.wdata[31:16] : v.wdata[15:0]);
            if (v.lng) check("R8", "second beat lane", log_data[1], v.wdata[15:0]);
        end else begin
            exp_rd = v.lng ? {mem_word(wa), mem_word(wa + 1'b1)} : {16'h0, mem_word(wa)};
            check(v.lng ? "R8" : "R9", "read data", rd_data, exp_rd);
        end
        @(negedge clk);
        check("R10", "done width", {31'h0, done}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        for (int i = 0; i < NUM_CS; i++) begin
            cfg_sel = SEL_W'(i);
            #1;
            check("R1", "reset control word", cfg_rdata, 16'h3D80);
        end
        check("R12", "strobes idle after reset", bus_cs_n, 4'hF);
        check("R10", "done low after reset", done, 1'b0);

        // Reset settings: wait 15 with internal acknowledge
        run_vec('{2'd3, 16'h3D80, 1'b0, 1'b0, 4'd0, 32'h0000_0100, 32'h0}, 1'b0);

        // Reserved bits read as zero
        write_cfg(2'd2, 16'hFFFF);
        cfg_sel = 2'd2;
        #1;
        check("R1", "reserved bits", cfg_rdata, 16'h3DD8);

        // Vector table (R4: codes 00, 01, 11 appear in rows 2, 3, 1)
        for (int i = 0; i < 8; i++) run_vec(VECS[i], 1'b1);

        // Request during a transfer is ignored
        write_cfg(2'd0, 16'h0D80);
        ext_dly = 0;
        @(negedge clk);
        nbeats = 0; ndone = 0;
        req_valid = 1'b1; req_cs = 2'd0; req_addr = 32'h0000_0200;
        req_write = 1'b0; req_long = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_cs = 2'd1; req_addr = 32'h0000_0300;
        req_write = 1'b1; req_long = 1'b1; req_wdata = 32'h0BAD_0BAD;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        check("R11", "beats for ignored request", nbeats, 1);
        check("R11", "done pulses", ndone, 1);
        check("R11", "strobe of ignored request", {28'h0, log_cs[0]}, 32'h1);
        check("R11", "strobes idle afterwards", bus_cs_n, 4'hF);

        // Read data held after done
        held = rd_data;
        repeat (5) @(negedge clk);
        check("R10", "read data held", rd_data, {16'h0, mem_word(31'h100)});
        check("R10", "read data unchanged", rd_data, held);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule